// File: doc/BRIEF.md
# Serial Memory Burst Configuration Loader

This block runs once after reset, and again on every reload pulse. It reads an external serial configuration memory one byte at a time and turns the image it finds there into 32-bit register writes. The image starts with a tag byte, then gives a burst count. After that come the bursts. Each burst has a two-byte header, which names a starting word address and a word count, followed by four data bytes for every word. Words are written to consecutive register byte addresses, four apart.

A write is issued only when two external busy indications are both low. Some earlier master may still own the register path, so the loader holds each assembled word until that path is free. A size-select strap sets the highest memory byte address the loader may read. An image that would run past that address stops the loader and raises a sticky overflow flag. The `busy` output is high while the loader is working and falls when it reaches its finished wait state.

Top module: `cfg_burst_loader`

## Requirements
- R1: After reset, `busy` is 1, `overflow` is 0 and `wr_en` is 0. The first read request is for memory address 0.
- R2: If the byte at address 0 is not A5h, no write is issued and `busy` falls.
- R3: The byte at address 1 is the number of bursts. A value of 0 ends the load with no write.
- R4: A burst header is two bytes, read high byte first. Header bits 15:7 are a word address and bits 6:0 are a word count. The first write of the burst goes to byte address (word address × 4) on the 11-bit `wr_addr`.
- R5: Data bytes are packed least significant byte first into `wr_data`. Successive words of a burst go to byte addresses that rise by 4.
- R6: A burst whose word count is 0 issues no write, and the next byte is read as the following burst's header.
- R7: `wr_en` is asserted only in the cycle after a clock edge at which both `csr_busy` and `pmi_busy` were sampled low. While either busy input stays high, no write happens.
- R8: With strap value s, the highest readable byte address is 128·2^s − 1. If the next byte would come from a higher address, the loader issues no read. It sets `overflow`, drops `busy`, and `overflow` stays set until a reload.
- R9: After the last burst, `busy` is 0 and `rd_req` and `wr_en` stay 0.
- R10: A one-cycle `reload` pulse clears `overflow`, sets `busy` and restarts parsing from memory address 0.
- R11: A read request holds `rd_req` high with a stable `rd_addr` until the cycle in which `rd_valid` returns the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | 1 | One-cycle request to restart the load |
| size_sel | input | SEL_W | Memory size strap |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | MEM_AW | Memory byte address of the request |
| rd_valid | input | 1 | Requested byte is present on rd_data |
| rd_data | input | 8 | Returned memory byte |
| csr_busy | input | 1 | Register-path busy indication |
| pmi_busy | input | 1 | PHY-management busy indication |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 11 | Register byte address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Loader active |
| overflow | output | 1 | Sticky memory-limit overflow flag |

## Verification
The bench aims at a wrong tag byte and a zero burst count. A design that got these wrong would write garbage or never finish. It also covers zero-length bursts, where an off-by-one would eat the next header as data, and the top header address 1FFh, where a bad shift would lose the upper bits. It holds each busy input high on its own to catch a write that ignores one interlock. Finally, it places images so they end exactly on the size limit and one burst past it. A loose comparison would then either flag a legal image or read beyond memory.

// File: rtl/cfg_burst_loader.sv
module cfg_burst_loader #(
  parameter int MEM_AW     = 16,
  parameter int SEL_W      = 3,
  parameter int BASE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [SEL_W-1:0]  size_sel,
  output logic              rd_req,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  input  logic              csr_busy,
  input  logic              pmi_busy,
  output logic              wr_en,
  output logic [10:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              overflow
);
  localparam logic [7:0] TAG = 8'hA5;

  typedef enum logic [1:0] {S_FETCH, S_HOLD, S_DONE} st_t;
  typedef enum logic [2:0] {F_TAG, F_NUM, F_HHI, F_HLO, F_DAT} fld_t;

  st_t         st;
  fld_t        fld;
  logic [7:0]  bursts_left, hdr_hi;
  logic [8:0]  dw_addr;
  logic [6:0]  words_left;
  logic [1:0]  idx;
  logic [31:0] word;
  logic [MEM_AW:0] lim;

  assign lim      = ((MEM_AW+1)'(BASE_BYTES) << size_sel) - (MEM_AW+1)'(1);
  wire past_end   = {1'b0, rd_addr} > lim;
  assign rd_req   = (st == S_FETCH) && !past_end;
  assign busy     = (st != S_DONE);
  wire gate_open  = !csr_busy && !pmi_busy;
  wire last_burst = (bursts_left == 8'd1);
  wire last_word  = (words_left == 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FETCH; fld <= F_TAG; rd_addr <= '0; overflow <= 1'b0;
      bursts_left <= '0; hdr_hi <= '0; dw_addr <= '0; words_left <= '0;
      idx <= '0; word <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else if (reload) begin
      st <= S_FETCH; fld <= F_TAG; rd_addr <= '0; overflow <= 1'b0;
      wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (st)
        S_FETCH: begin
          if (past_end) begin
            overflow <= 1'b1;
            st       <= S_DONE;
          end else if (rd_valid) begin
            rd_addr <= rd_addr + MEM_AW'(1);
            case (fld)
              F_TAG: if (rd_data == TAG) fld <= F_NUM; else st <= S_DONE;
              F_NUM: begin
                bursts_left <= rd_data;
                if (rd_data == 8'd0) st <= S_DONE; else fld <= F_HHI;
              end
              F_HHI: begin hdr_hi <= rd_data; fld <= F_HLO; end
              F_HLO: begin
                dw_addr    <= {hdr_hi, rd_data[7]};
                words_left <= rd_data[6:0];
                idx        <= 2'd0;
                if (rd_data[6:0] != 7'd0) fld <= F_DAT;
                else if (last_burst) st <= S_DONE;
                else begin bursts_left <= bursts_left - 8'd1; fld <= F_HHI; end
              end
              default: begin
                word[{idx, 3'b000} +: 8] <= rd_data;
                idx <= idx + 2'd1;
                if (idx == 2'd3) st <= S_HOLD;
              end
            endcase
          end
        end
        S_HOLD: if (gate_open) begin
          wr_en      <= 1'b1;
          wr_addr    <= {dw_addr, 2'b00};
          wr_data    <= word;
          dw_addr    <= dw_addr + 9'd1;
          words_left <= words_left - 7'd1;
          if (!last_word) st <= S_FETCH;
          else if (last_burst) st <= S_DONE;
          else begin
            bursts_left <= bursts_left - 8'd1;
            fld <= F_HHI;
            st  <= S_FETCH;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module cfg_burst_loader_chk #(
  parameter int MEM_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reload,
  input logic              rd_req,
  input logic [MEM_AW-1:0] rd_addr,
  input logic              rd_valid,
  input logic              csr_busy,
  input logic              pmi_busy,
  input logic              wr_en,
  input logic              busy,
  input logic              overflow
);
  a_r7_busy_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!csr_busy && !pmi_busy));
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid && !reload |=> rd_req && $stable(rd_addr));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !reload |=> overflow);
  a_r8_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !busy && !rd_req);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !reload |=> !wr_en && !rd_req);
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> busy && !overflow && rd_addr == '0);
endmodule

bind cfg_burst_loader cfg_burst_loader_chk #(.MEM_AW(MEM_AW)) u_chk (.*);

// File: tb/cfg_burst_loader_tb.sv
`timescale 1ns/1ps
module cfg_burst_loader_tb;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0, reload = 0, rd_valid = 0, csr_busy = 0, pmi_busy = 0;
  logic [2:0] size_sel = 3'd4;
  logic [7:0] rd_data = 0;
  logic rd_req, wr_en, busy, overflow;
  logic [15:0] rd_addr;
  logic [10:0] wr_addr;
  logic [31:0] wr_data;

  cfg_burst_loader u_dut (.clk, .rst_n, .reload, .size_sel, .rd_req, .rd_addr,
    .rd_valid, .rd_data, .csr_busy, .pmi_busy, .wr_en, .wr_addr, .wr_data,
    .busy, .overflow);

  logic [7:0]  mem [0:4095];
  logic [10:0] ex_a [0:1023];
  logic [31:0] ex_d [0:1023];
  logic [10:0] g_a [0:1023];
  logic [31:0] g_d [0:1023];
  int ex_n, g_n, wp, lat, bz_mode;
  bit ex_ovf, prev_c, prev_p, finished;
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin rd_valid <= 0; lat <= 0; end
    else begin
      rd_valid <= 0;
      if (rd_req && !rd_valid) begin
        if (lat == 0) begin
          rd_valid <= 1;
          rd_data  <= (rd_addr < 16'd4096) ? mem[rd_addr[11:0]] : 8'hFF;
          lat      <= int'($urandom_range(0, 2));
        end else lat <= lat - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      chk(!prev_c && !prev_p, "R7", "write with busy high", {prev_c, prev_p}, 0);
      if (g_n < 1024) begin g_a[g_n] = wr_addr; g_d[g_n] = wr_data; end
      g_n++;
    end
    case (bz_mode)
      1: begin csr_busy = ($urandom % 4) == 0; pmi_busy = ($urandom % 4) == 0; end
      2: begin csr_busy = 1; pmi_busy = 0; end
      3: begin csr_busy = 0; pmi_busy = 1; end
      default: begin csr_busy = 0; pmi_busy = 0; end
    endcase
    prev_c = csr_busy; prev_p = pmi_busy;
  end

  function automatic bit fetch(inout int p, input int lim, output logic [7:0] b);
    if (p > lim) return 0;
    b = (p < 4096) ? mem[p] : 8'hFF;
    p++;
    return 1;
  endfunction

  task automatic model(input int lim);
    int p = 0;
    logic [7:0] b, nb, hi, lo;
    logic [8:0] a;
    logic [31:0] d;
    ex_n = 0; ex_ovf = 0;
    if (!fetch(p, lim, b)) begin ex_ovf = 1; return; end
    if (b != 8'hA5) return;
    if (!fetch(p, lim, nb)) begin ex_ovf = 1; return; end
    for (int bi = 0; bi < int'(nb); bi++) begin
      if (!fetch(p, lim, hi)) begin ex_ovf = 1; return; end
      if (!fetch(p, lim, lo)) begin ex_ovf = 1; return; end
      a = {hi, lo[7]};
      for (int w = 0; w < int'(lo[6:0]); w++) begin
        for (int k = 0; k < 4; k++) begin
          if (!fetch(p, lim, b)) begin ex_ovf = 1; return; end
          d[8*k +: 8] = b;
        end
        ex_a[ex_n] = {a, 2'b00}; ex_d[ex_n] = d; ex_n++; a = a + 9'd1;
      end
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    wp = 0;
  endtask
  task automatic put(input logic [7:0] b); mem[wp] = b; wp++; endtask
  task automatic hdr(input logic [8:0] a, input logic [6:0] c);
    put(a[8:1]); put({a[0], c});
  endtask
  task automatic data_words(input int c);
    for (int i = 0; i < 4 * c; i++) put(8'($urandom));
  endtask

  task automatic run(input logic [2:0] sel, input bit by_reset, input string req);
    int t = 0;
    size_sel = sel;
    g_n = 0;
    model((128 << sel) - 1);
    @(negedge clk);
    if (by_reset) begin
      rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
      chk(busy && !overflow && !wr_en, "R1", "state after reset", {busy, overflow, wr_en}, 3'b100);
      chk(rd_req && rd_addr == 0, "R1", "first request", {rd_req, rd_addr}, {1'b1, 16'd0});
    end else begin
      reload = 1; @(negedge clk); reload = 0;
      chk(busy && !overflow && rd_addr == 0, "R10", "state after reload",
          {busy, overflow, rd_addr}, {2'b10, 16'd0});
    end
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, req, "load finished", t, 0);
    repeat (10) @(negedge clk);
    chk(!rd_req && !wr_en && !busy, "R9", "quiet after finish", {rd_req, wr_en, busy}, 0);
    chk(overflow == ex_ovf, "R8", "overflow flag", overflow, ex_ovf);
    chk(g_n == ex_n, req, "write count", g_n, ex_n);
    for (int i = 0; i < ex_n && i < g_n; i++) begin
      chk(g_a[i] == ex_a[i], "R4", "write address", g_a[i], ex_a[i]);
      chk(g_d[i] == ex_d[i], "R5", "write data", g_d[i], ex_d[i]);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bz_mode = 0;
    clear_mem(); put(8'hA5); put(8'd3);
    hdr(9'h010, 7'd1); put(8'h11); put(8'h12); put(8'h13); put(8'h14);
    hdr(9'h020, 7'd2); data_words(2);
    hdr(9'h030, 7'd3); data_words(3);
    run(3'd4, 1, "R4");
    chk(g_a[0] == 11'h040 && g_d[0] == 32'h14131211, "R4", "first write of example",
        {g_a[0], g_d[0]}, {11'h040, 32'h14131211});
    chk(g_a[2] == 11'h084, "R5", "second word of burst two", g_a[2], 11'h084);

    clear_mem(); put(8'h5A); put(8'd1); hdr(9'h001, 7'd1); data_words(1);
    run(3'd4, 0, "R2");
    chk(g_n == 0, "R2", "no writes on bad tag", g_n, 0);

    clear_mem(); put(8'hA5); put(8'd0); hdr(9'h001, 7'd1); data_words(1);
    run(3'd4, 0, "R3");

    clear_mem(); put(8'hA5); put(8'd3);
    hdr(9'h005, 7'd2); data_words(2); hdr(9'h050, 7'd0); hdr(9'h060, 7'd1); data_words(1);
    run(3'd4, 0, "R6");
    chk(g_a[2] == 11'h180, "R6", "burst after empty one", g_a[2], 11'h180);

    clear_mem(); put(8'hA5); put(8'd1); hdr(9'h1FF, 7'd1); data_words(1);
    run(3'd4, 0, "R4");
    chk(g_a[0] == 11'h7FC, "R4", "top header address", g_a[0], 11'h7FC);

    for (int m = 2; m <= 3; m++) begin
      clear_mem(); put(8'hA5); put(8'd1); hdr(9'h002, 7'd2); data_words(2);
      size_sel = 3'd4; model(2047); bz_mode = m; g_n = 0;
      @(negedge clk); reload = 1; @(negedge clk); reload = 0;
      repeat (60) @(negedge clk);
      chk(g_n == 0, "R7", "held by one busy input", g_n, 0);
      bz_mode = 0;
      repeat (30) @(negedge clk);
      chk(g_n == 2 && !busy, "R7", "released writes", g_n, 2);
    end

    bz_mode = 1;
    for (int r = 0; r < 8; r++) begin
      int nb;
      clear_mem(); put(8'hA5);
      nb = int'($urandom_range(1, 6)); put(8'(nb));
      for (int b = 0; b < nb; b++) begin
        int c = int'($urandom_range(0, 8));
        hdr(9'($urandom), 7'(c)); data_words(c);
      end
      run(3'($urandom_range(3, 7)), 0, "R5");
    end
    bz_mode = 0;

    clear_mem(); put(8'hA5); put(8'd1); hdr(9'h000, 7'd31); data_words(31);
    run(3'd0, 0, "R8");
    chk(!overflow && g_n == 31, "R8", "image ending on limit", {overflow, g_n}, 31);

    clear_mem(); put(8'hA5); put(8'd1); hdr(9'h040, 7'd40); data_words(40);
    run(3'd0, 0, "R8");
    chk(overflow && g_n == 31, "R8", "stop past limit", {overflow, g_n}, {1'b1, 32'd31});
    repeat (20) @(negedge clk);
    chk(overflow && !rd_req, "R8", "overflow sticky", {overflow, rd_req}, 2'b10);

    run(3'd4, 0, "R10");
    chk(!overflow && g_n == 40, "R10", "recovered after reload", {overflow, g_n}, 40);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule